// File: doc/BRIEF.md
# Shared-Pool Outstanding Request Tracker

This block remembers every outstanding request of a network interface in one shared attribute store instead of a fixed queue per ID. Each active ID owns a singly linked chain of storage entries, kept in the order its requests arrived. A request takes a free entry from a recycling list, stores the attributes and a split count, and joins its ID's chain at the tail. A response for an ID reads the attributes of that chain's head entry in the same cycle. Once every sub-response of that entry has returned, the entry goes back to the pool.

Because any ID may use any entry, the store needs only as many entries as the total number of outstanding requests, not IDs times depth. Responses for different IDs may come back in any order. Responses for one ID always return attributes in request order.

Top module: `ll_tracker`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, `push_ready` is 1 and `id_active` is all zero.
- R2: An accepted push (`push_valid` and `push_ready`) sets the `id_active` bit of `push_id` from the next cycle on.
- R3: Successive responses for one ID return the attributes of that ID's requests in the order the requests were accepted.
- R4: Responses for different IDs may be interleaved in any order, and each returns the oldest pending attributes of its own ID.
- R5: While `rsp_valid` is high and `rsp_id` is active, `rsp_attr` shows the head entry's attributes in the same cycle, with no clock edge in between.
- R6: `push_splits` holds the number of expected sub-responses minus one. An entry pushed with value k answers k+1 responses with the same attributes. `rsp_last` is 1 only on the final one, and only then does the entry retire.
- R7: When the last entry of an ID retires and no push for that ID arrives in the same cycle, that ID's `id_active` bit clears on the next cycle.
- R8: A single ID may occupy every entry of the pool. With all entries in use, `full` is 1, `push_ready` is 0, and a push is ignored.
- R9: A response for an inactive ID raises `rsp_err` in that cycle with `rsp_last` 0, and leaves `id_active`, `full` and `empty` unchanged.
- R10: A push and a retiring response for the same ID in one cycle, on a chain of one entry, leave the ID active with the new request as its only pending entry.
- R11: A retired entry returns to the pool and is available to a later push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | New request present |
| push_ready | output | 1 | A free entry exists |
| push_id | input | IW | Compressed ID of the request |
| push_attr | input | ATTR_W | Attributes to store |
| push_splits | input | SPLIT_W | Sub-responses expected minus one |
| rsp_valid | input | 1 | Response present |
| rsp_id | input | IW | ID of the response |
| rsp_attr | output | ATTR_W | Head attributes of `rsp_id` |
| rsp_last | output | 1 | This response retires the head entry |
| rsp_err | output | 1 | Response for an inactive ID |
| id_active | output | NUM_IDS | Per-ID outstanding flag |
| full | output | 1 | No free entry |
| empty | output | 1 | No outstanding entry |

## Verification
The hardest state to reach is a push and a retiring response on the same ID in one cycle, while that ID's chain holds exactly one entry. Here head and tail both move to the new entry and the ID must stay active. The bench sets this up with one lone push, then drives both ports together in the next cycle. It then checks that the next response returns the new attributes and that the ID goes inactive after it. Pool exhaustion by one ID, followed by reuse of a retired entry, is reached by filling the pool from a single ID and draining it completely.

// File: rtl/ll_tracker.sv
module ll_tracker #(
  parameter int NUM_IDS     = 4,
  parameter int NUM_ENTRIES = 8,
  parameter int ATTR_W      = 8,
  parameter int SPLIT_W     = 3,
  localparam int IW = $clog2(NUM_IDS),
  localparam int EW = $clog2(NUM_ENTRIES),
  localparam int CW = EW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  output logic               push_ready,
  input  logic [IW-1:0]      push_id,
  input  logic [ATTR_W-1:0]  push_attr,
  input  logic [SPLIT_W-1:0] push_splits,
  input  logic               rsp_valid,
  input  logic [IW-1:0]      rsp_id,
  output logic [ATTR_W-1:0]  rsp_attr,
  output logic               rsp_last,
  output logic               rsp_err,
  output logic [NUM_IDS-1:0] id_active,
  output logic               full,
  output logic               empty
);
  logic [ATTR_W-1:0]  attr_q [NUM_ENTRIES];
  logic [SPLIT_W-1:0] left_q [NUM_ENTRIES];
  logic [EW-1:0]      nxt_q  [NUM_ENTRIES];
  logic [EW-1:0]      pool_q [NUM_ENTRIES];
  logic [EW-1:0]      head_q [NUM_IDS];
  logic [EW-1:0]      tail_q [NUM_IDS];
  logic [EW-1:0]      rd_q, wr_q;
  logic [CW-1:0]      nfree_q;

  logic [EW-1:0] alloc, hd;
  logic push_do, rsp_do, retire;

  assign alloc      = pool_q[rd_q];
  assign hd         = head_q[rsp_id];
  assign full       = (nfree_q == '0);
  assign empty      = (nfree_q == CW'(NUM_ENTRIES));
  assign push_ready = !full;
  assign push_do    = push_valid && push_ready;
  assign rsp_do     = rsp_valid && id_active[rsp_id];
  assign retire     = rsp_do && (left_q[hd] == '0);
  assign rsp_attr   = attr_q[hd];
  assign rsp_last   = retire;
  assign rsp_err    = rsp_valid && !id_active[rsp_id];

  function automatic logic [EW-1:0] wrap_inc(input logic [EW-1:0] p);
    return (p == EW'(NUM_ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        pool_q[i] <= EW'(i);
        attr_q[i] <= '0;
        left_q[i] <= '0;
        nxt_q[i]  <= '0;
      end
      for (int j = 0; j < NUM_IDS; j++) begin
        head_q[j] <= '0;
        tail_q[j] <= '0;
      end
      id_active <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
      nfree_q   <= CW'(NUM_ENTRIES);
    end else begin
      if (push_do) begin
        attr_q[alloc] <= push_attr;
        left_q[alloc] <= push_splits;
        if (id_active[push_id]) nxt_q[tail_q[push_id]] <= alloc;
        rd_q <= wrap_inc(rd_q);
      end
      if (rsp_do && !retire) left_q[hd] <= left_q[hd] - 1'b1;
      if (retire) begin
        pool_q[wr_q] <= hd;
        wr_q <= wrap_inc(wr_q);
      end
      nfree_q <= nfree_q - CW'(push_do) + CW'(retire);
      for (int j = 0; j < NUM_IDS; j++) begin
        logic pu, re, single;
        pu     = push_do && (push_id == IW'(j));
        re     = retire && (rsp_id == IW'(j));
        single = (head_q[j] == tail_q[j]);
        if (pu) begin
          if (!id_active[j] || (re && single)) begin
            head_q[j]    <= alloc;
            tail_q[j]    <= alloc;
            id_active[j] <= 1'b1;
          end else begin
            tail_q[j] <= alloc;
            if (re) head_q[j] <= nxt_q[head_q[j]];
          end
        end else if (re) begin
          if (single) id_active[j] <= 1'b0;
          else        head_q[j]    <= nxt_q[head_q[j]];
        end
      end
    end
  end
endmodule

// File: rtl/ll_tracker_chk.sv
module ll_tracker_chk #(
  parameter int NUM_IDS     = 4,
  parameter int NUM_ENTRIES = 8,
  localparam int IW = $clog2(NUM_IDS),
  localparam int CW = $clog2(NUM_ENTRIES) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               push_valid,
  input logic               push_ready,
  input logic [IW-1:0]      push_id,
  input logic               rsp_valid,
  input logic               rsp_last,
  input logic               rsp_err,
  input logic [NUM_IDS-1:0] id_active,
  input logic               full,
  input logic               empty
);
  logic [CW-1:0] outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else outstanding <= outstanding + CW'(push_valid && push_ready) - CW'(rsp_last);
  end

  assert_pool_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CW'(NUM_ENTRIES));
  assert_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full == (outstanding == CW'(NUM_ENTRIES)));
  assert_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (outstanding == '0));
  assert_err_no_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_last);
  assert_err_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !push_valid) |=> $stable(id_active));
  assert_push_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> id_active[$past(push_id)]);
endmodule

bind ll_tracker ll_tracker_chk #(.NUM_IDS(NUM_IDS), .NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
  .push_id(push_id), .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_err(rsp_err),
  .id_active(id_active), .full(full), .empty(empty));

// File: tb/ll_tracker_tb_top.sv
`timescale 1ns/1ps
module ll_tracker_tb_top;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_ready, rsp_valid = 0, rsp_last, rsp_err, full, empty;
  logic [1:0] push_id = 0, rsp_id = 0;
  logic [7:0] push_attr = 0, rsp_attr;
  logic [2:0] push_splits = 0;
  logic [3:0] id_active;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ll_tracker dut_i (.clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_id(push_id), .push_attr(push_attr), .push_splits(push_splits), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .rsp_attr(rsp_attr), .rsp_last(rsp_last), .rsp_err(rsp_err),
    .id_active(id_active), .full(full), .empty(empty));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {push, rsp, id[2], attr[8], splits[3], exp_attr[8], exp_last, exp_err}
  localparam logic [24:0] VEC [9] = '{
    {1'b1, 1'b0, 2'd1, 8'hA1, 3'd0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd1, 8'hA2, 3'd0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'hB1, 3'd1, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd2, 8'h00, 3'd0, 8'hB1, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd1, 8'h00, 3'd0, 8'hA1, 1'b1, 1'b0},
    {1'b0, 1'b1, 2'd2, 8'h00, 3'd0, 8'hB1, 1'b1, 1'b0},
    {1'b1, 1'b0, 2'd2, 8'hB2, 3'd0, 8'h00, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'd1, 8'h00, 3'd0, 8'hA2, 1'b1, 1'b0},
    {1'b0, 1'b1, 2'd2, 8'h00, 3'd0, 8'hB2, 1'b1, 1'b0}
  };

  task automatic step(input logic p, input logic r, input logic [1:0] pid, input logic [1:0] rid,
                      input logic [7:0] a, input logic [2:0] s);
    @(negedge clk);
    push_valid = p; rsp_valid = r; push_id = pid; rsp_id = rid; push_attr = a; push_splits = s;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    push_valid = 0; rsp_valid = 0;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 ready", push_ready, 1); chk("R1 active", id_active, 0);

    foreach (VEC[k]) begin
      step(VEC[k][24], VEC[k][23], VEC[k][22:21], VEC[k][22:21], VEC[k][20:13], VEC[k][12:10]);
      #1;
      if (VEC[k][23]) begin
        chk("R3 R4 R5 attr", rsp_attr, VEC[k][9:2]);
        chk("R6 last", rsp_last, VEC[k][1]);
        chk("R9 err", rsp_err, VEC[k][0]);
      end
      idle();
      if (k == 0) chk("R2 active", id_active[1], 1);
    end
    chk("R7 inactive", id_active, 0);
    chk("R7 empty", empty, 1);

    // R9: response to inactive id
    step(0, 1, 0, 3, 0, 0); #1;
    chk("R9 err", rsp_err, 1); chk("R9 last", rsp_last, 0);
    idle();
    chk("R9 active", id_active, 0); chk("R9 empty", empty, 1); chk("R9 full", full, 0);

    // R8: one id fills whole pool
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 3, 0, 8'h40 + 8'(i), 0); idle();
    end
    chk("R8 full", full, 1); chk("R8 ready", push_ready, 0);
    step(1, 0, 3, 0, 8'hEE, 0); idle();
    chk("R8 still full", full, 1);
    // R11: retire one, reuse entry
    step(0, 1, 0, 3, 0, 0); #1;
    chk("R3 first", rsp_attr, 8'h40);
    idle();
    chk("R11 ready", push_ready, 1);
    step(1, 0, 3, 0, 8'h50, 0); idle();
    chk("R11 full again", full, 1);
    for (int i = 1; i < 9; i++) begin
      step(0, 1, 0, 3, 0, 0); #1;
      chk("R3 R11 order", rsp_attr, (i < 8) ? 8'h40 + 8'(i) : 8'h50);
      chk("R8 refused push absent", rsp_attr == 8'hEE, 0);
      idle();
    end
    chk("R7 drained", id_active[3], 0); chk("R11 empty", empty, 1);

    // R10: push + retire same id, single entry
    step(1, 0, 0, 0, 8'h11, 0); idle();
    step(1, 1, 0, 0, 8'h22, 0); #1;
    chk("R10 attr", rsp_attr, 8'h11); chk("R10 last", rsp_last, 1);
    idle();
    chk("R10 active", id_active[0], 1);
    step(0, 1, 0, 0, 0, 0); #1;
    chk("R10 new head", rsp_attr, 8'h22); chk("R10 last2", rsp_last, 1);
    idle();
    chk("R10 inactive", id_active[0], 0); chk("R10 empty", empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule